// File: doc/BRIEF.md
# ADC Test Pattern Generator

This block sits on the 12-bit sample path of a data converter, just before the serial lanes. It can replace the live samples with a known digital pattern so that the link and the capture logic can be checked without an analog signal. It offers three patterns: a user word set by software, a ramp, and a fixed alternating deskew word. It then splits the 12-bit word into two 6-bit lanes.

Software sets it up through a plain write port with an 8-bit address and 8-bit data. A test enable chooses between live samples and the pattern. The ramp comes from a 14-bit free-running counter. Only its upper 12 bits reach the output, so the visible ramp rises by one step every four clocks. A write to the alignment register restarts the ramp. In two-wire mode, a swap control exchanges the two halves between the lanes.

Top module: `pattern_lane_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, both lanes, all control registers and the ramp counter go to zero. Writes made during reset have no effect.
- R2: With test mode off, the value on `sample_i` before an edge appears on the lanes after that edge, one clock of latency.
- R3: Writing a value with bit 1 set to address 06h turns test mode on. Writing 00h there turns it off, and samples flow again.
- R4: Select code 5h outputs the user word. Its bits [11:4] come from address 0Eh bits [7:0] and its bits [3:0] from address 0Fh bits [7:4].
- R5: Select code 4h outputs bits [13:2] of a 14-bit counter that adds one on every clock, so the ramp steps once every four clocks.
- R6: The ramp counter wraps from 16383 to 0, so the ramp returns to zero after 16384 clocks.
- R7: Select code 6h outputs the fixed word AAAh (1010... with the MSB set).
- R8: Any other select code (address 0Ah bits [3:0]) outputs zero while test mode is on.
- R9: Without swap, lane 0 carries word bits [5:0] and lane 1 carries bits [11:6].
- R10: With two-wire mode (address 10h bit 0) and swap (address 10h bit 1) both set, lane 0 carries bits [11:6] and lane 1 carries bits [5:0].
- R11: The swap bit has no effect while two-wire mode is off.
- R12: A write to address 09h with bit 1 set clears the ramp counter at that edge. A write to any unmapped address changes nothing.
- R13: A write takes effect at the edge that accepts it, so it shapes the output one edge later. With `wr_en` low, nothing is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| sample_i | input | 12 | Live converter sample |
| lane0_o | output | 6 | Output lane 0 |
| lane1_o | output | 6 | Output lane 1 |

## Verification
The bench runs the ramp through a full counter wrap. A design that counted only 12 bits, or stepped on every clock, would go out of step with the reference at once. It checks that the user word is assembled with the 0Eh byte in the upper bits, which catches a swapped or misaligned half. It sets swap while two-wire mode is off, so that a design gating swap on the wrong condition shows exchanged lanes. It also writes the alignment register and an unmapped address, which exposes a counter that fails to restart or that restarts on stray writes.

// File: rtl/pattern_lane_pkg.sv
// Shared constants and types for the test pattern generator.
// Assumes a 12-bit sample word split into two equal lanes.
package pattern_lane_pkg;
    localparam int unsigned WORD_W  = 12;
    localparam int unsigned LANE_W  = WORD_W / 2;
    localparam int unsigned RAMP_W  = 14;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned SEL_W   = 4;

    localparam logic [REG_W-1:0] ADR_TEST  = 8'h06;
    localparam logic [REG_W-1:0] ADR_ALIGN = 8'h09;
    localparam logic [REG_W-1:0] ADR_SEL   = 8'h0A;
    localparam logic [REG_W-1:0] ADR_UHI   = 8'h0E;
    localparam logic [REG_W-1:0] ADR_ULO   = 8'h0F;
    localparam logic [REG_W-1:0] ADR_LANE  = 8'h10;

    localparam logic [SEL_W-1:0] CODE_RAMP   = 4'h4;
    localparam logic [SEL_W-1:0] CODE_USER   = 4'h5;
    localparam logic [SEL_W-1:0] CODE_DESKEW = 4'h6;

    localparam logic [WORD_W-1:0] DESKEW_WORD = {(WORD_W/2){2'b10}};

    typedef struct packed {
        logic              test_on;
        logic [SEL_W-1:0]  sel;
        logic [WORD_W-1:0] user;
        logic              two_wire;
        logic              swap;
    } tpg_cfg_t;
endpackage

// File: rtl/tpg_regfile.sv
// Control register bank written through an address/data strobe.
// Assumes writes land on the clock edge that samples wr_en; no read path.
module tpg_regfile
    import pattern_lane_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output tpg_cfg_t         cfg_o,
    output logic             align_o
);
    localparam int unsigned UHI_W = WORD_W - 4;

    tpg_cfg_t cfg_q;

    // Capture addressed fields; reset clears every field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_TEST: cfg_q.test_on <= wr_data[1];
                ADR_SEL:  cfg_q.sel <= wr_data[SEL_W-1:0];
                ADR_UHI:  cfg_q.user[WORD_W-1:4] <= wr_data[UHI_W-1:0];
                ADR_ULO:  cfg_q.user[3:0] <= wr_data[7:4];
                ADR_LANE: begin
                    cfg_q.two_wire <= wr_data[0];
                    cfg_q.swap     <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

    // Alignment request is a strobe, not a stored bit.
    always_comb align_o = rst_n && wr_en && (wr_addr == ADR_ALIGN) && wr_data[1];

    assign cfg_o = cfg_q;

    p_user_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_UHI) |=> cfg_o.user[WORD_W-1:4] == $past(wr_data[UHI_W-1:0]));

    p_hold_no_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> cfg_o == $past(cfg_o));
endmodule

// File: rtl/tpg_ramp.sv
// Free-running ramp counter; output is the top OUT_W bits of CNT_W.
// Assumes CNT_W >= OUT_W; clear has priority over counting.
module tpg_ramp #(
    parameter int unsigned CNT_W = 14,
    parameter int unsigned OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [OUT_W-1:0] ramp_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count every clock, restart on reset or alignment strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assign ramp_o = cnt_q[CNT_W-1 -: OUT_W];

    p_ramp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    p_ramp_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0);
endmodule

// File: rtl/tpg_lane_map.sv
// Registers the word and maps its halves onto two lanes.
// Assumes an even word width; swap_i already folds in two-wire mode.
module tpg_lane_map #(
    parameter int unsigned LW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*LW-1:0] word_i,
    input  logic            swap_i,
    output logic [LW-1:0]   lane0_o,
    output logic [LW-1:0]   lane1_o
);
    // Register lanes, exchanging halves when swap is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane0_o <= '0;
            lane1_o <= '0;
        end else if (swap_i) begin
            lane0_o <= word_i[2*LW-1:LW];
            lane1_o <= word_i[LW-1:0];
        end else begin
            lane0_o <= word_i[LW-1:0];
            lane1_o <= word_i[2*LW-1:LW];
        end
    end

    p_lane_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> (lane0_o == $past(word_i[LW-1:0])) && (lane1_o == $past(word_i[2*LW-1:LW])));

    p_lane_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> (lane0_o == $past(word_i[2*LW-1:LW])) && (lane1_o == $past(word_i[LW-1:0])));
endmodule

// File: rtl/pattern_lane_gen.sv
// Test pattern generator: chooses live sample or pattern, maps to lanes.
// Assumes one sample per clock; output latency is one clock.
module pattern_lane_gen
    import pattern_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [WORD_W-1:0] sample_i,
    output logic [LANE_W-1:0] lane0_o,
    output logic [LANE_W-1:0] lane1_o
);
    tpg_cfg_t          cfg;
    logic              align;
    logic [WORD_W-1:0] ramp;
    logic [WORD_W-1:0] pattern;
    logic [WORD_W-1:0] word;
    logic              swap;

    tpg_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_o(cfg), .align_o(align)
    );

    tpg_ramp #(.CNT_W(RAMP_W), .OUT_W(WORD_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .clr_i(align), .ramp_o(ramp)
    );

    // Decode the pattern select code; unknown codes give zero.
    always_comb begin
        case (cfg.sel)
            CODE_RAMP:   pattern = ramp;
            CODE_USER:   pattern = cfg.user;
            CODE_DESKEW: pattern = DESKEW_WORD;
            default:     pattern = '0;
        endcase
    end

    // Choose between live sample and pattern; swap only in two-wire mode.
    always_comb begin
        word = cfg.test_on ? pattern : sample_i;
        swap = cfg.two_wire & cfg.swap;
    end

    tpg_lane_map #(.LW(LANE_W)) u_map (
        .clk(clk), .rst_n(rst_n), .word_i(word), .swap_i(swap),
        .lane0_o(lane0_o), .lane1_o(lane1_o)
    );

    p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.test_on && !swap) |=> {lane1_o, lane0_o} == $past(sample_i));
endmodule

// File: tb/pattern_lane_gen_test.sv
module pattern_lane_gen_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int         due;
        logic [5:0] e0;
        logic [5:0] e1;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [11:0] sample_i = '0;
    logic [5:0] lane0_o, lane1_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    exp_t q[$];

    // reference model state
    bit         m_test, m_two, m_swap;
    logic [3:0] m_sel;
    logic [11:0] m_user;
    int         m_cnt;

    pattern_lane_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sample_i(sample_i), .lane0_o(lane0_o), .lane1_o(lane1_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare lanes against due expectations
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t it;
            it = q.pop_front();
            total++;
            if (lane0_o !== it.e0 || lane1_o !== it.e1) begin
                bad++;
                $display("FAIL %s: lanes=%h/%h expected=%h/%h", it.req, lane0_o, lane1_o, it.e0, it.e1);
            end
        end
    end

    // driver: one clock with optional write; pushes expected result
    task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d,
                        input logic [11:0] smp, input string req);
        exp_t it;
        logic [11:0] w, pat;
        wr_en = we; wr_addr = a; wr_data = d; sample_i = smp;
        if (!rst_n) begin
            it.e0 = '0; it.e1 = '0;
            m_test = 0; m_two = 0; m_swap = 0; m_sel = '0; m_user = '0; m_cnt = 0;
        end else begin
            case (m_sel)
                4'h4: pat = 12'(m_cnt >> 2);
                4'h5: pat = m_user;
                4'h6: pat = 12'hAAA;
                default: pat = '0;
            endcase
            w = m_test ? pat : smp;
            if (m_two && m_swap) begin it.e0 = w[11:6]; it.e1 = w[5:0]; end
            else                 begin it.e0 = w[5:0];  it.e1 = w[11:6]; end
            if (we && a == 8'h09 && d[1]) m_cnt = 0;
            else                          m_cnt = (m_cnt + 1) % 16384;
            if (we) begin
                case (a)
                    8'h06: m_test = d[1];
                    8'h0A: m_sel = d[3:0];
                    8'h0E: m_user[11:4] = d;
                    8'h0F: m_user[3:0] = d[7:4];
                    8'h10: begin m_two = d[0]; m_swap = d[1]; end
                    default: ;
                endcase
            end
        end
        it.due = cyc + 1;
        it.req = req;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n, input logic [11:0] smp, input string req);
        for (int i = 0; i < n; i++) step(0, 8'h00, 8'h00, smp + 12'(i * 37), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: cycles=200000 expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        // R1: reset with writes attempted
        step(1, 8'h06, 8'h02, 12'hFFF, "R1");
        step(1, 8'h0A, 8'h06, 12'h123, "R1");
        step(0, 8'h00, 8'h00, 12'h456, "R1");
        rst_n = 1'b1;
        // R2: live samples pass through (also shows R1 writes were lost)
        step(0, 8'h00, 8'h00, 12'h5A3, "R2");
        step(0, 8'h00, 8'h00, 12'h0FC, "R2");
        idle(6, 12'h801, "R2");
        // R13: user word written while test off; samples still flow
        step(1, 8'h0E, 8'hA5, 12'h111, "R13");
        step(1, 8'h0F, 8'h3C, 12'h222, "R13");
        step(1, 8'h0A, 8'h05, 12'h333, "R13");
        step(1, 8'h06, 8'h02, 12'h444, "R3");
        idle(4, 12'h0F0, "R4");
        // R13: strobe low must not write
        step(0, 8'h06, 8'h00, 12'h555, "R13");
        idle(3, 12'h777, "R13");
        // R12: unmapped address write ignored
        step(1, 8'h20, 8'hFF, 12'h999, "R12");
        idle(2, 12'h999, "R12");
        // R9 / R10 / R11 lane mapping
        step(1, 8'h10, 8'h01, 12'h000, "R9");
        idle(2, 12'h000, "R9");
        step(1, 8'h10, 8'h03, 12'h000, "R10");
        idle(3, 12'h000, "R10");
        step(1, 8'h10, 8'h02, 12'h000, "R11");
        idle(3, 12'h000, "R11");
        step(1, 8'h10, 8'h00, 12'h000, "R9");
        // R7 deskew, R8 unknown codes
        step(1, 8'h0A, 8'h06, 12'h000, "R7");
        idle(3, 12'h000, "R7");
        step(1, 8'h0A, 8'h07, 12'h000, "R8");
        idle(2, 12'h000, "R8");
        step(1, 8'h0A, 8'h0F, 12'h000, "R8");
        idle(2, 12'h000, "R8");
        step(1, 8'h0A, 8'h00, 12'h000, "R8");
        idle(2, 12'h000, "R8");
        // R5 ramp with alignment restart (R12)
        step(1, 8'h0A, 8'h04, 12'h000, "R5");
        idle(5, 12'h000, "R5");
        step(1, 8'h09, 8'h02, 12'h000, "R12");
        idle(40, 12'h000, "R5");
        step(1, 8'h09, 8'h01, 12'h000, "R12");
        idle(10, 12'h000, "R12");
        step(1, 8'h10, 8'h03, 12'h000, "R10");
        idle(8, 12'h000, "R10");
        // R6 full wrap of the counter
        idle(16400, 12'h000, "R6");
        // R3 test off returns live samples
        step(1, 8'h06, 8'h00, 12'h6B2, "R3");
        idle(4, 12'h3C9, "R3");
        step(0, 8'h00, 8'h00, 12'h000, "R3");
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule